// File: doc/BRIEF.md
# USB OTG Interrupt Aggregator

This block collects interrupt requests from a USB OTG core and presents them to a host CPU as one active-high interrupt line. Hardware event pulses for transmit endpoints, receive endpoints and core events set bits in two source registers: one for endpoints, one for core events. Software reaches each group through a small set of 32-bit words on a simple register bus. It can read the raw source, set or clear source bits with write-one aliases, set or clear enable bits in a mask with its own aliases, and read the source ANDed with the mask.

The interrupt line fires once per service pass. After it has risen, it cannot rise again until software writes the end-of-interrupt word, even when enabled sources are still pending. A soft reset bit in the control word clears all sources and masks and re-arms the line. A status word reports the level of a VBUS-drive input pin, and a revision word reads a fixed nonzero identifier.

Top module: `usb_irq_glue`

## Requirements
- R1: A read of byte offset 0x00 returns the nonzero parameter REV_ID. A read of 0x08 returns the `vbus_drive` pin level on bit 0 and zero on every other bit.
- R2: A write to 0x24 (endpoint) or 0x44 (core) sets each source bit where the written data has a one and leaves every other bit unchanged. The raw source reads back at 0x20 and 0x40, and writes to those two offsets have no effect.
- R3: A write to 0x28 (endpoint) or 0x48 (core) clears each source bit where the written data has a one and leaves every other bit unchanged.
- R4: A write to 0x30 or 0x50 sets mask bits, and a write to 0x34 or 0x54 clears mask bits, in each case only where the data has a one. The masks read back at 0x2C and 0x4C.
- R5: A read of 0x38 or 0x58 returns the group's source ANDed with its mask.
- R6: The following read as zero: endpoint bit 16, core bits outside 24:16, any offset not listed in these requirements (including 0x04), and `rdata` whenever `rd_en` is low. Writes to reserved bits are ignored.
- R7: A pulse on `ep_tx_evt[k]` sets endpoint bit k. A pulse on `ep_rx_evt[k]` sets endpoint bit 16+k. A pulse on `core_evt[k]` sets core bit 16+k. Each takes effect at the clock edge that samples the pulse. When a hardware pulse and a software clear hit the same bit in the same cycle, the bit stays set.
- R8: When the block is armed and any bit of source AND mask is nonzero in either group, `irq` rises at the next clock edge. While every masked bit is zero, `irq` stays low.
- R9: After `irq` has risen, it does not rise again until a write to 0x60. `irq` falls one edge after the masked sources become all zero, and it falls at the edge that samples the write to 0x60.
- R10: When masked sources are still pending, a write to 0x60 drops `irq` for exactly one cycle, after which it rises again.
- R11: A write to 0x04 with bit 0 set clears both sources and both masks, drops `irq` and re-arms the block. A write to 0x04 with bit 0 clear changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, zero when rd_en is low |
| ep_tx_evt | input | 16 | Transmit endpoint event pulses, endpoints 0 to 15 |
| ep_rx_evt | input | 15 | Receive endpoint event pulses, endpoints 1 to 15 (index 15:1) |
| core_evt | input | CORE_BITS | Core event pulses; the highest is the VBUS-drive event |
| vbus_drive | input | 1 | VBUS-drive level reported in the status word |
| irq | output | 1 | Interrupt line to the CPU, active high |

## Verification
The register paths are driven with all-ones writes, which expose the reserved bits that must stay zero. Partial clear patterns show that set and clear affect only the bits written as one. Masks that overlap the sources only in part show that the masked view is a true AND and not a copy of either register. The interrupt line is tried with a pending source behind a zero mask, where it must stay low. It is also tried with a new event that arrives after service but before end-of-interrupt, where it must stay low until the write. A third pattern writes end-of-interrupt with work still pending, which must give a one-cycle gap and then a rise. A hardware pulse that lands on the same bit as a software clear tells set-wins priority apart from clear-wins priority.

// File: rtl/usb_irq_glue.sv
module usb_irq_glue #(
  parameter int          ADDR_W    = 8,
  parameter int          CORE_BITS = 9,
  parameter int          CORE_LSB  = 16,
  parameter logic [31:0] REV_ID    = 32'h0001_0A00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [15:0]       ep_tx_evt,
  input  logic [15:1]       ep_rx_evt,
  input  logic [CORE_BITS-1:0] core_evt,
  input  logic              vbus_drive,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_REV   = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_EP    = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_CORE  = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_EOI   = ADDR_W'(8'h60);
  localparam logic [ADDR_W-1:0] O_SET   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] O_CLR   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] O_MSK   = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] O_MSET  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] O_MCLR  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] O_MVIEW = ADDR_W'(8'h18);
  localparam logic [31:0] EP_VALID   = 32'hFFFE_FFFF;
  localparam logic [31:0] CORE_VALID = 32'(((64'd1 << CORE_BITS) - 64'd1) << CORE_LSB);

  logic [31:0] ep_src, ep_mask, core_src, core_mask;
  logic        fired, irq_q;

  function automatic logic [31:0] next_bits(
    input logic [31:0] cur, input logic set_en, input logic clr_en,
    input logic [31:0] d, input logic [31:0] hw, input logic [31:0] valid);
    logic [31:0] s, c;
    s = set_en ? d : '0;
    c = clr_en ? d : '0;
    return ((cur & ~c) | s | hw) & valid;
  endfunction

  wire soft_rst = wr_en && addr == A_CTRL && wdata[0];
  wire eoi_wr   = wr_en && addr == A_EOI;

  logic [31:0] ep_hw, core_hw;
  assign ep_hw   = {ep_rx_evt, 1'b0, ep_tx_evt};
  assign core_hw = 32'(core_evt) << CORE_LSB;

  wire pending = |(ep_src & ep_mask) | |(core_src & core_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep_src <= '0; ep_mask <= '0; core_src <= '0; core_mask <= '0;
    end else if (soft_rst) begin
      ep_src <= '0; ep_mask <= '0; core_src <= '0; core_mask <= '0;
    end else begin
      ep_src    <= next_bits(ep_src, wr_en && addr == A_EP + O_SET,
                             wr_en && addr == A_EP + O_CLR, wdata, ep_hw, EP_VALID);
      ep_mask   <= next_bits(ep_mask, wr_en && addr == A_EP + O_MSET,
                             wr_en && addr == A_EP + O_MCLR, wdata, '0, EP_VALID);
      core_src  <= next_bits(core_src, wr_en && addr == A_CORE + O_SET,
                             wr_en && addr == A_CORE + O_CLR, wdata, core_hw, CORE_VALID);
      core_mask <= next_bits(core_mask, wr_en && addr == A_CORE + O_MSET,
                             wr_en && addr == A_CORE + O_MCLR, wdata, '0, CORE_VALID);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired <= 1'b0; irq_q <= 1'b0;
    end else if (soft_rst || eoi_wr) begin
      fired <= 1'b0; irq_q <= 1'b0;
    end else if (!fired && pending) begin
      fired <= 1'b1; irq_q <= 1'b1;
    end else if (!pending) begin
      irq_q <= 1'b0;
    end
  end

  assign irq = irq_q;

  logic [31:0] rmux;
  always_comb begin
    case (addr)
      A_REV:           rmux = REV_ID;
      A_STAT:          rmux = {31'b0, vbus_drive};
      A_EP:            rmux = ep_src;
      A_EP + O_MSK:    rmux = ep_mask;
      A_EP + O_MVIEW:  rmux = ep_src & ep_mask;
      A_CORE:          rmux = core_src;
      A_CORE + O_MSK:  rmux = core_mask;
      A_CORE + O_MVIEW: rmux = core_src & core_mask;
      default:         rmux = '0;
    endcase
  end

  assign rdata = rd_en ? rmux : '0;
endmodule

module usb_irq_glue_chk #(
  parameter int ADDR_W    = 8,
  parameter int CORE_BITS = 9,
  parameter int CORE_LSB  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [15:0]       ep_tx_evt,
  input logic              irq,
  input logic [31:0]       ep_src,
  input logic [31:0]       ep_mask,
  input logic [31:0]       core_src,
  input logic [31:0]       core_mask
);
  localparam logic [31:0] CORE_OK = 32'(((64'd1 << CORE_BITS) - 64'd1) << CORE_LSB);
  wire srst = wr_en && addr == ADDR_W'(8'h04) && wdata[0];
  wire eoi  = wr_en && addr == ADDR_W'(8'h60);
  wire pend = ((ep_src & ep_mask) != 0) || ((core_src & core_mask) != 0);
  logic seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else if (srst || eoi) seen <= 1'b0;
    else if (irq) seen <= 1'b1;

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ep_src[16] == 1'b0 && (core_src & ~CORE_OK) == 32'h0);
  assert_hw_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_tx_evt != 0 && !srst) |=> ((ep_src[15:0] & $past(ep_tx_evt)) == $past(ep_tx_evt)));
  assert_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && pend && !seen && !eoi && !srst) |=> irq);
  assert_drop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !pend) |=> !irq);
  assert_eoi_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !irq);
  assert_no_refire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !seen);
  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!irq && ep_src == 0 && ep_mask == 0 && core_src == 0 && core_mask == 0));
endmodule

bind usb_irq_glue usb_irq_glue_chk #(.ADDR_W(ADDR_W), .CORE_BITS(CORE_BITS), .CORE_LSB(CORE_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ep_tx_evt(ep_tx_evt), .irq(irq), .ep_src(ep_src), .ep_mask(ep_mask),
  .core_src(core_src), .core_mask(core_mask));

// File: tb/usb_irq_glue_bench.sv
`timescale 1ns/1ps
module usb_irq_glue_bench;
  localparam logic [31:0] REV = 32'h0001_0A00;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, vbus_drive = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, got;
  logic [15:0] ep_tx_evt = '0;
  logic [15:1] ep_rx_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        irq;
  int tests = 0, fails = 0;
  bit done = 0;

  usb_irq_glue u_usb_irq_glue (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ep_tx_evt(ep_tx_evt), .ep_rx_evt(ep_rx_evt),
    .core_evt(core_evt), .vbus_drive(vbus_drive), .irq(irq));

  always #2.5 clk = ~clk;

  // {write, addr, data, expected}
  localparam int NV = 24;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0,         REV},
    {1'b1, 8'h30, 32'h0003_0005, 32'h0},
    {1'b0, 8'h2C, 32'h0,         32'h0002_0005},
    {1'b1, 8'h34, 32'h0000_0001, 32'h0},
    {1'b0, 8'h2C, 32'h0,         32'h0002_0004},
    {1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h20, 32'h0,         32'hFFFE_FFFF},
    {1'b1, 8'h28, 32'h0F0F_0000, 32'h0},
    {1'b0, 8'h20, 32'h0,         32'hF0F0_FFFF},
    {1'b1, 8'h20, 32'h0,         32'h0},
    {1'b0, 8'h20, 32'h0,         32'hF0F0_FFFF},
    {1'b0, 8'h38, 32'h0,         32'h0000_0004},
    {1'b1, 8'h50, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h4C, 32'h0,         32'h01FF_0000},
    {1'b1, 8'h54, 32'h0100_0000, 32'h0},
    {1'b0, 8'h4C, 32'h0,         32'h00FF_0000},
    {1'b1, 8'h44, 32'h0180_0001, 32'h0},
    {1'b0, 8'h40, 32'h0,         32'h0180_0000},
    {1'b0, 8'h58, 32'h0,         32'h0080_0000},
    {1'b1, 8'h48, 32'h0080_0000, 32'h0},
    {1'b0, 8'h40, 32'h0,         32'h0100_0000},
    {1'b0, 8'h10, 32'h0,         32'h0},
    {1'b0, 8'h5C, 32'h0,         32'h0},
    {1'b0, 8'h08, 32'h0,         32'h0}
  };

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00, 8'h08: return "R1 revision/status";
      8'h20, 8'h40: return "R2 R3 source";
      8'h2C, 8'h4C: return "R4 mask";
      8'h38, 8'h58: return "R5 masked view";
      default:      return "R6 reserved";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R8 irq low after reset", {31'b0, irq}, 32'h0);
    rd(8'h20, got); chk("R2 ep source reset", got, 32'h0);
    rd(8'h4C, got); chk("R4 core mask reset", got, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:64], got);
        chk(tag_of(VEC[i][71:64]), got, VEC[i][31:0]);
      end
    end

    @(negedge clk); rd_en = 1'b0; addr = 8'h00; #1;
    chk("R6 rdata zero without rd_en", rdata, 32'h0);
    vbus_drive = 1'b1;
    rd(8'h08, got); chk("R1 status vbus", got, 32'h1);
    rd(8'h04, got); chk("R6 control reads zero", got, 32'h0);

    // R11: bit 0 clear does nothing, bit 0 set clears everything
    wr(8'h04, 32'hFFFF_FFFE);
    rd(8'h20, got); chk("R11 no-op control write", got, 32'hF0F0_FFFF);
    wr(8'h04, 32'h1);
    chk("R11 irq low after soft reset", {31'b0, irq}, 32'h0);
    rd(8'h20, got); chk("R11 ep source cleared", got, 32'h0);
    rd(8'h2C, got); chk("R11 ep mask cleared", got, 32'h0);
    rd(8'h40, got); chk("R11 core source cleared", got, 32'h0);
    rd(8'h4C, got); chk("R11 core mask cleared", got, 32'h0);

    // R8: pending source behind zero mask stays quiet
    wr(8'h24, 32'h0000_0002);
    repeat (3) @(negedge clk);
    chk("R8 masked-off source no irq", {31'b0, irq}, 32'h0);
    wr(8'h30, 32'h0000_0002);
    chk("R8 irq not yet at mask edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq after mask set", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h1);

    // R7: hardware events
    wr(8'h30, 32'h0000_0008);
    @(negedge clk); ep_tx_evt[3] = 1'b1;
    @(negedge clk); ep_tx_evt[3] = 1'b0;
    chk("R7 R8 irq one edge after event", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq raised by tx event", {31'b0, irq}, 32'h1);
    @(negedge clk); ep_rx_evt[5] = 1'b1;
    @(negedge clk); ep_rx_evt[5] = 1'b0;
    rd(8'h20, got); chk("R7 rx event bit 21", got, 32'h0020_0008);
    @(negedge clk); core_evt[8] = 1'b1;
    @(negedge clk); core_evt[8] = 1'b0;
    rd(8'h40, got); chk("R7 core event bit 24", got, 32'h0100_0000);

    // R9: service, new event, no refire until end-of-interrupt
    wr(8'h28, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R9 irq drops when sources cleared", {31'b0, irq}, 32'h0);
    @(negedge clk); ep_tx_evt[3] = 1'b1;
    @(negedge clk); ep_tx_evt[3] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 no refire before EOI", {31'b0, irq}, 32'h0);
    wr(8'h60, 32'h0);
    chk("R10 irq low at EOI edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 irq refires after EOI", {31'b0, irq}, 32'h1);
    wr(8'h60, 32'h0);
    chk("R9 EOI drops irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 second refire with pending", {31'b0, irq}, 32'h1);

    // R7: hardware set beats software clear
    @(negedge clk); wr_en = 1'b1; addr = 8'h28; wdata = 32'h0000_0008; ep_tx_evt[3] = 1'b1;
    @(negedge clk); wr_en = 1'b0; ep_tx_evt[3] = 1'b0;
    rd(8'h20, got); chk("R7 set wins over clear", got, 32'h0000_0008);
    wr(8'h28, 32'h0000_0008);
    rd(8'h38, got); chk("R3 R5 cleared masked view", got, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule